// File: doc/BRIEF.md
# Serial-Input Parallel-Output FIFO

This block buffers a bit-serial stream as parallel words. Bits are shifted into an assembly register one per shift strobe, least-significant first. A separate commit strobe stores the bits gathered so far as one 9-bit word in a dual-port RAM. Because the commit strobe decides where a word ends, 8-bit or shorter words can share the 9-bit array: unfilled upper bits are stored as zero. Words leave through a 9-bit read port in first-in first-out order. The read port shows the oldest word without a prior read request, so a consumer sees a word in the same cycle that the FIFO stops being empty.

All activity runs on one system clock. The shift, commit, read and retransmit inputs are one-cycle enable strobes. Five registered flags report occupancy: empty, almost-empty, half-full, almost-full and full. A retransmit strobe moves the read side back to location zero so that everything written since reset can be read again. This is meaningful only while fewer than DEPTH words have been written since reset.

Top module: `sipo_fifo`

## Requirements
- R1: On each cycle with `ser_shift` high, `ser_in` fills the next free bit of the assembly register, starting at bit 0 (least-significant bit first). At most 9 bits are held. Further shifts before a commit are dropped.
- R2: An accepted `next_wr` stores the assembled word, with any unfilled bit positions set to zero. A shift in the same cycle is included as the next bit. The assembly register then restarts empty.
- R3: `next_wr` while `full` is high is ignored. The stored contents and flags do not change, and the partially assembled bits are kept for a later commit.
- R4: `rd_en` while `empty` is high is ignored. Occupancy and the read position do not change.
- R5: After the clock edge that accepts a commit into an empty FIFO, `empty` is low and `rd_data` already shows that word, with no read strobe.
- R6: Whenever `empty` is low, `rd_data` shows the oldest stored word. An accepted read moves it to the next word at the following edge. Without a read or retransmit, `rd_data` stays stable.
- R7: A read and a commit accepted in the same cycle leave the occupancy unchanged and keep word order. This includes the case where one word is stored and the newly written word becomes the head.
- R8: `empty` is high exactly when occupancy is 0, and `full` is high exactly when occupancy equals DEPTH. Both are registered and reflect the occupancy after the latest edge.
- R9: `half_full` is high when occupancy is at least DEPTH/2.
- R10: `almost_full` is high when occupancy is at least DEPTH − DEPTH/8. `almost_empty` is high when occupancy is at most DEPTH/8.
- R11: `retx` sets the read position to location 0 and sets the occupancy to the number of words written since reset (this holds while that number is below DEPTH). A read or commit strobed in the same cycle is ignored, but a shift is still taken.
- R12: `rst` is synchronous and active high. It clears both pointers, the occupancy and the assembly register. Afterwards only `empty` and `almost_empty` are high.
- R13: DEPTH is a power-of-two parameter of at least 8. It defaults to 2048 and also supports 4096. Pointers wrap modulo DEPTH, and order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| ser_shift | input | 1 | Shift strobe: take `ser_in` this cycle |
| next_wr | input | 1 | Commit strobe: store the assembled word |
| rd_en | input | 1 | Read strobe: advance to the next word |
| retx | input | 1 | Retransmit strobe: restart reading at location 0 |
| rd_data | output | 9 | Oldest stored word (valid while `empty` is low) |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| half_full | output | 1 | Occupancy at least DEPTH/2 |
| almost_full | output | 1 | Occupancy at least DEPTH − DEPTH/8 |
| almost_empty | output | 1 | Occupancy at most DEPTH/8 |

## Verification
The bench builds the FIFO with DEPTH set to 16. This gives thresholds of 2 (almost-empty), 8 (half-full) and 14 (almost-full). Filling the FIFO to full, overflowing it, draining it and wrapping the pointers each take only a few hundred cycles. The same value also brings the single-word bypass case within reach, where a read and a commit happen together at occupancy one. A retransmit taken after a partial drain is also covered. Word assembly is driven with full 9-bit words, 8-bit and 3-bit words, over-long shift bursts, and commits that coincide with the last shift.

// File: rtl/sipo_fifo_pkg.sv
package sipo_fifo_pkg;

  localparam int WORD_W = 9;

  typedef struct packed {
    logic full;
    logic empty;
    logic half;
    logic afull;
    logic aempty;
  } fifo_flags_t;

  localparam fifo_flags_t FLAGS_RESET = '{full: 1'b0, empty: 1'b1, half: 1'b0,
                                         afull: 1'b0, aempty: 1'b1};

endpackage

// File: rtl/sipo_shifter.sv
module sipo_shifter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         ser_bit,
  input  logic         take,
  output logic [W-1:0] word_o
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [CW-1:0] fill;
  logic [W-1:0]  merged;
  logic          room;

  assign room = (fill < CW'(W));

  always_comb begin
    merged = acc;
    for (int i = 0; i < W; i++) begin
      if (shift_en && room && fill == CW'(i)) merged[i] = ser_bit;
    end
  end

  assign word_o = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      fill <= '0;
    end else if (take) begin
      acc  <= '0;
      fill <= '0;
    end else if (shift_en && room) begin
      acc  <= merged;
      fill <= fill + CW'(1);
    end
  end

  // R1: never more than W bits held
  a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(W));

  // R2: an accepted commit leaves an empty assembly register
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    take |=> (fill == '0 && acc == '0));

  // R1: a shift with no room leaves the held bits alone
  a_r1_drop_extra: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !room && !take) |=> $stable(acc));

endmodule

// File: rtl/sipo_fifo_ram.sv
module sipo_fifo_ram #(
  parameter int W     = 9,
  parameter int DEPTH = 2048
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sipo_fifo_ctrl.sv
module sipo_fifo_ctrl
  import sipo_fifo_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit_req,
  input  logic                     rd_req,
  input  logic                     retx,
  output logic                     wr_fire,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [$clog2(DEPTH)-1:0] rd_addr_nx,
  output logic                     byp_hit,
  output fifo_flags_t              flags
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_T  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_T  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] AFULL_T = CW'(DEPTH - DEPTH / 8);
  localparam logic [CW-1:0] AEMPT_T = CW'(DEPTH / 8);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cnt_nx;
  fifo_flags_t   flags_q, flags_nx;
  logic          rd_fire;

  always_comb begin
    wr_fire    = commit_req && !flags_q.full && !retx;
    rd_fire    = rd_req && !flags_q.empty && !retx;
    rd_addr_nx = retx ? '0 : (rd_fire ? rd_ptr + AW'(1) : rd_ptr);
    byp_hit    = wr_fire && (wr_ptr == rd_addr_nx);

    if (retx) begin
      cnt_nx = {1'b0, wr_ptr};
    end else begin
      cnt_nx = count;
      if (wr_fire) cnt_nx = cnt_nx + CW'(1);
      if (rd_fire) cnt_nx = cnt_nx - CW'(1);
    end

    flags_nx.full   = (cnt_nx == FULL_T);
    flags_nx.empty  = (cnt_nx == '0);
    flags_nx.half   = (cnt_nx >= HALF_T);
    flags_nx.afull  = (cnt_nx >= AFULL_T);
    flags_nx.aempty = (cnt_nx <= AEMPT_T);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      flags_q <= FLAGS_RESET;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr  <= rd_addr_nx;
      count   <= cnt_nx;
      flags_q <= flags_nx;
    end
  end

  assign wr_addr = wr_ptr;
  assign flags   = flags_q;

  // R3: no commit is taken while full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (flags_q.full && !retx) |=> (wr_ptr == $past(wr_ptr)));

  // R4: no read is taken while empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (flags_q.empty && !retx) |=> (rd_ptr == $past(rd_ptr)));

  // R7: simultaneous read and commit keep occupancy
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && rd_fire) |=> $stable(count));

  // R8: full and empty never together
  a_r8_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(flags_q.full && flags_q.empty));

  // R9/R10: full implies the upper threshold flags
  a_r10_full_thresholds: assert property (@(posedge clk) disable iff (rst)
    flags_q.full |-> (flags_q.half && flags_q.afull && !flags_q.aempty));

  // R8: occupancy never exceeds capacity
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_T);

  // R11: retransmit restarts reading at location 0
  a_r11_retx_ptr: assert property (@(posedge clk) disable iff (rst)
    retx |=> (rd_ptr == '0));

  // R12: reset leaves only empty and almost-empty set
  a_r12_reset_flags: assert property (@(posedge clk)
    rst |=> (flags_q.empty && flags_q.aempty && !flags_q.full &&
             !flags_q.half && !flags_q.afull));

endmodule

// File: rtl/sipo_fifo.sv
module sipo_fifo
  import sipo_fifo_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              ser_shift,
  input  logic              next_wr,
  input  logic              rd_en,
  input  logic              retx,
  output logic [WORD_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              half_full,
  output logic              almost_full,
  output logic              almost_empty
);

  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] asm_word, ram_q, byp_word;
  logic [AW-1:0]     wr_addr, rd_addr_nx;
  logic              wr_fire, byp_hit, byp_q;
  fifo_flags_t       flags;

  sipo_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (ser_shift),
    .ser_bit  (ser_in),
    .take     (wr_fire),
    .word_o   (asm_word)
  );

  sipo_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .commit_req (next_wr),
    .rd_req     (rd_en),
    .retx       (retx),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .rd_addr_nx (rd_addr_nx),
    .byp_hit    (byp_hit),
    .flags      (flags)
  );

  sipo_fifo_ram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (asm_word),
    .raddr (rd_addr_nx),
    .rdata (ram_q)
  );

  // Write-to-head bypass covers the RAM's read-during-write latency
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q    <= 1'b0;
      byp_word <= '0;
    end else begin
      byp_q <= byp_hit;
      if (byp_hit) byp_word <= asm_word;
    end
  end

  assign rd_data      = byp_q ? byp_word : ram_q;
  assign full         = flags.full;
  assign empty        = flags.empty;
  assign half_full    = flags.half;
  assign almost_full  = flags.afull;
  assign almost_empty = flags.aempty;

  // R6: head word stable while no read or retransmit
  a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd_en && !retx) |=> $stable(rd_data));

  // R5: a commit into an empty FIFO clears empty at the next edge
  a_r5_fall_through: assert property (@(posedge clk) disable iff (rst)
    (empty && next_wr && !retx) |=> !empty);

endmodule

// File: tb/test_sipo_fifo.sv
module test_sipo_fifo;

  localparam int DEPTH = 16;
  localparam int W     = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, ser_shift = 1'b0, next_wr = 1'b0, rd_en = 1'b0, retx = 1'b0;
  logic [W-1:0] rd_data;
  logic full, empty, half_full, almost_full, almost_empty;

  sipo_fifo #(.DEPTH(DEPTH)) i_sipo_fifo (
    .clk, .rst, .ser_in, .ser_shift, .next_wr, .rd_en, .retx,
    .rd_data, .full, .empty, .half_full, .almost_full, .almost_empty
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R12";

  logic [W-1:0] q[$];
  logic [W-1:0] hist[$];
  logic [W-1:0] m_acc = '0;
  int m_n = 0;

  task automatic chk(input string sig, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", phase, sig, act, exp);
    end
  endtask

  task automatic compare();
    int n = q.size();
    chk("R8 empty", W'(empty), W'(n == 0));
    chk("R8 full", W'(full), W'(n == DEPTH));
    chk("R9 half_full", W'(half_full), W'(n >= DEPTH / 2));
    chk("R10 almost_full", W'(almost_full), W'(n >= DEPTH - DEPTH / 8));
    chk("R10 almost_empty", W'(almost_empty), W'(n <= DEPTH / 8));
    if (n > 0) chk("R6 rd_data", rd_data, q[0]);
  endtask

  task automatic model(input logic sh, input logic b, input logic nw, input logic rd, input logic rt);
    logic [W-1:0] asmw = m_acc;
    bit wrok, rdok;
    if (sh && m_n < W) asmw[m_n] = b;
    wrok = nw && !rt && q.size() < DEPTH;
    rdok = rd && !rt && q.size() > 0;
    if (rt) q = hist;
    if (rdok) void'(q.pop_front());
    if (wrok) begin
      q.push_back(asmw);
      hist.push_back(asmw);
    end
    if (wrok) begin
      m_acc = '0;
      m_n = 0;
    end else if (sh && m_n < W) begin
      m_acc = asmw;
      m_n++;
    end
  endtask

  task automatic step(input logic sh, input logic b, input logic nw, input logic rd, input logic rt);
    ser_shift = sh; ser_in = b; next_wr = nw; rd_en = rd; retx = rt;
    @(posedge clk); #1;
    model(sh, b, nw, rd, rt);
    compare();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ser_shift = 0; ser_in = 0; next_wr = 0; rd_en = 0; retx = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete(); hist.delete(); m_acc = '0; m_n = 0;
  endtask

  task automatic send_word(input logic [15:0] val, input int nbits, input bit commit_last);
    for (int i = 0; i < nbits; i++) step(1'b1, val[i], commit_last && i == nbits - 1, 1'b0, 1'b0);
    if (!commit_last) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    phase = "R12 after reset";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    phase = "R1 R5 nine-bit word";
    send_word(16'h01A5, 9, 0);
    phase = "R6 idle hold";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    phase = "R2 eight-bit zero fill";
    send_word(16'h00C3, 8, 1);
    phase = "R2 three-bit word";
    send_word(16'h0005, 3, 0);
    phase = "R1 extra shifts dropped";
    send_word(16'h05A3, 11, 0);

    phase = "R4 drain and read empty";
    read_n(4);
    read_n(2);

    phase = "R9 R10 fill to full";
    for (int k = 0; k < DEPTH; k++) send_word(16'(k * 37 + 11), 9, 1);
    phase = "R3 commit while full";
    send_word(16'h0009, 4, 0);
    step(0, 0, 1, 0, 0);
    phase = "R3 kept bits after read";
    read_n(1);
    step(0, 0, 1, 0, 0);

    phase = "R7 simultaneous read and commit";
    for (int k = 0; k < 6; k++) step(1, k[0], 1, 1, 0);
    phase = "R10 drain";
    read_n(DEPTH - 1);
    phase = "R7 bypass at one word";
    for (int k = 0; k < 5; k++) step(1, ~k[0], 1, 1, 0);
    read_n(1);
    phase = "R4 read and commit while empty";
    step(1, 1, 1, 1, 0);
    read_n(2);

    do_reset();
    phase = "R11 retransmit";
    for (int k = 0; k < 5; k++) send_word(16'(k * 53 + 7), 9, 1);
    read_n(3);
    send_word(16'h0003, 2, 0);
    step(1, 1, 1, 1, 1);
    read_n(7);
    step(0, 0, 0, 0, 1);
    read_n(2);

    do_reset();
    phase = "R13 pointer wrap";
    for (int k = 0; k < 40; k++) begin
      send_word(16'(k * 29 + 3), 9, 1);
      if (k % 3 != 0) read_n(1);
    end
    read_n(DEPTH + 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule